// File: doc/BRIEF.md
# Prioritized Interrupt State Vector

This block holds the pending-event flags of a serial bus controller and turns them into one vector byte that interrupt software adds straight to a jump-table base. Eight event sources each own a flag. A one-cycle set strobe latches a flag, and a software clear strobe releases it. The vector names the most urgent pending source. A single request line goes to the interrupt controller. That line is gated by an enable bit and by an ignore mode. The ignore mode also freezes the flags while the receiver is told to disregard the current message.

Software reads the vector, dispatches on it and clears the flag it served. On the next read the vector names the next most urgent source. The vector reads zero once every flag is clear.

Top module: `irq_state_vector`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, every flag is clear, vector reads 0x00 and irq_req is 0.
- R2: With no flag pending, vector is 0x00.
- R3: Source i sits on bit i of set_stb and clr_stb. Priority rises with i: 0 end-of-frame, 1 response byte, 2 receive full, 3 transmit empty, 4 arbitration lost, 5 CRC error, 6 invalid symbol, 7 wakeup. With flags pending, vector equals 4*(h+1), where h is the highest pending index (0x04 up to 0x20).
- R4: A set strobe latches its flag at the next rising clock edge. The flag then stays pending, with no further strobes, until a clear strobe for it is taken.
- R5: When the highest pending flag is cleared, vector shows the next highest pending source, or 0x00, in the cycle right after the clearing edge.
- R6: irq_req is 1 only when irq_en is 1. It equals irq_en AND NOT ignore_msg AND (any flag pending).
- R7: While ignore_msg is 1, irq_req is 0.
- R8: While ignore_msg is 1, set and clear strobes have no effect, so the flags and vector keep their values.
- R9: A set and a clear of the same flag in the same cycle leave the flag pending.
- R10: Vector bits 7:6 and 1:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_stb | input | 8 | Per-source set strobes, bit i = source i |
| clr_stb | input | 8 | Per-source clear strobes from software |
| irq_en | input | 1 | Interrupt request enable |
| ignore_msg | input | 1 | Masks irq_req and freezes the flags |
| vector | output | 8 | Jump-table offset of the highest pending source |
| irq_req | output | 1 | Gated interrupt request |

## Verification
Each source is raised alone to confirm its vector code. Flags are then stacked and cleared from the top down, which checks that the ladder steps to the next lower source and not back to a stale one. Random sparse set and clear patterns with a fixed seed are checked against a bench model. These mix the enable and ignore controls, so they also separate masking of the request from freezing of the flags. Directed cycles with a set and a clear on the same source show which strobe wins, and a frozen window with strobes present shows that those strobes leave no trace.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int unsigned SRC_COUNT = 8;
   localparam int unsigned VEC_WIDTH = 8;
   localparam int unsigned STEP_LG2  = 2;
   typedef logic [VEC_WIDTH-1:0] vec_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_stb,
   input  logic [N-1:0] clr_stb,
   input  logic         freeze,
   output logic [N-1:0] pend
);
   if (N < 1) begin : g_bad_n
      $error("irq_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend[i] <= 1'b0;
         else if (!freeze) begin
            if (set_stb[i])
               pend[i] <= 1'b1;
            else if (clr_stb[i])
               pend[i] <= 1'b0;
         end
      end

      // R4: a taken set strobe leaves the flag pending
      a_r4_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
         (!freeze && set_stb[i]) |=> pend[i]);
      // R9: set beats clear in the same cycle
      a_r9_set_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (!freeze && set_stb[i] && clr_stb[i]) |=> pend[i]);
   end

   // R8: frozen flags do not move
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(pend));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N        = 8,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned STEP_LG2 = 2
) (
   input  logic [N-1:0]     pend,
   output logic [VEC_W-1:0] vec
);
   localparam int unsigned IDX_W = $clog2(N + 1);

   if (VEC_W < IDX_W + STEP_LG2) begin : g_bad_w
      $error("irq_prio_enc: VEC_W too narrow for N sources");
   end

   logic [IDX_W-1:0] idx_chain [N+1];
   assign idx_chain[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_ladder
      assign idx_chain[i+1] = pend[i] ? IDX_W'(i + 1) : idx_chain[i];
   end

   assign vec = VEC_W'({idx_chain[N], {STEP_LG2{1'b0}}});
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] pend,
   input  logic         irq_en,
   input  logic         mask,
   output logic         irq_req
);
   assign irq_req = irq_en && !mask && (|pend);
endmodule

// File: rtl/irq_state_vector.sv
module irq_state_vector
   import irq_vec_pkg::*;
#(
   parameter int unsigned N = SRC_COUNT
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_stb,
   input  logic [N-1:0] clr_stb,
   input  logic         irq_en,
   input  logic         ignore_msg,
   output vec_t         vector,
   output logic         irq_req
);
   localparam int unsigned TOP_CODE = N << STEP_LG2;

   logic [N-1:0] pend;

   irq_flag_bank #(.N(N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb),
      .clr_stb (clr_stb),
      .freeze  (ignore_msg),
      .pend    (pend)
   );

   irq_prio_enc #(.N(N), .VEC_W(VEC_WIDTH), .STEP_LG2(STEP_LG2)) u_enc (
      .pend (pend),
      .vec  (vector)
   );

   irq_req_gate #(.N(N)) u_gate (
      .pend    (pend),
      .irq_en  (irq_en),
      .mask    (ignore_msg),
      .irq_req (irq_req)
   );

   // R2: idle vector
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> (vector == '0));
   // R3: top source dominates
   a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
      pend[N-1] |-> (vector == VEC_WIDTH'(TOP_CODE)));
   // R6: no request while disabled
   a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq_req);
   // R7: ignore mode masks the request
   a_r7_ignore_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ignore_msg |-> !irq_req);
   // R10: unused vector bits stay low
   a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (vector[1:0] == 2'b00) && (vector[VEC_WIDTH-1:6] == '0));
endmodule

// File: tb/tb_irq_state_vector.sv
module tb_irq_state_vector;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] set_stb = '0, clr_stb = '0;
   logic       irq_en = 1'b0, ignore_msg = 1'b0;
   logic [7:0] vector;
   logic       irq_req;

   int unsigned n_chk = 0, n_fail = 0;
   logic [7:0] model = '0;
   bit finished = 0;

   always #4 clk = ~clk;

   irq_state_vector dut (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
      .irq_en(irq_en), .ignore_msg(ignore_msg), .vector(vector), .irq_req(irq_req)
   );

   function automatic logic [7:0] exp_vec(input logic [7:0] f);
      logic [7:0] v = 8'h00;
      for (int i = 0; i < 8; i++) if (f[i]) v = 8'((i + 1) * 4);
      return v;
   endfunction

   function automatic logic exp_req(input logic [7:0] f, input logic en, input logic ign);
      return en && !ign && (f != 8'h00);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic [7:0] s, input logic [7:0] c, input logic en, input logic ign);
      @(negedge clk);
      set_stb = s; clr_stb = c; irq_en = en; ignore_msg = ign;
      @(posedge clk);
      if (!ign) model = (model & ~c) | s;
      #2;
   endtask

   task automatic check_all(input string tag);
      chk({tag, " vector"}, vector, exp_vec(model));
      chk({tag, " irq_req"}, {7'd0, irq_req}, {7'd0, exp_req(model, irq_en, ignore_msg)});
      chk("R10 unused bits", {vector[7:6], vector[1:0]}, 4'h0);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] snap;
      void'($urandom(32'd2024));
      irq_en = 1'b1;
      set_stb = 8'hFF;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset vector", vector, 8'h00);
      chk("R1 reset irq_req", {7'd0, irq_req}, 8'h00);
      @(negedge clk); rst_n = 1'b1; set_stb = '0;
      @(posedge clk); #2;
      chk("R1 after reset vector", vector, 8'h00);
      chk("R2 idle vector", vector, 8'h00);

      // R3: each source alone
      for (int i = 0; i < 8; i++) begin
         step(8'(1 << i), 8'h00, 1'b1, 1'b0);
         chk("R3 single source", vector, 8'((i + 1) * 4));
         check_all("R6");
         step(8'h00, 8'(1 << i), 1'b1, 1'b0);
         chk("R2 cleared", vector, 8'h00);
      end

      // R4: flag persists
      step(8'h08, 8'h00, 1'b1, 1'b0);
      repeat (4) step(8'h00, 8'h00, 1'b1, 1'b0);
      chk("R4 held flag", vector, 8'h10);
      step(8'h00, 8'h08, 1'b1, 1'b0);

      // R5: stack all, clear from top
      step(8'hFF, 8'h00, 1'b1, 1'b0);
      for (int i = 7; i >= 0; i--) begin
         step(8'h00, 8'(1 << i), 1'b1, 1'b0);
         chk("R5 next source", vector, 8'(i * 4));
      end

      // R9: set and clear same flag
      step(8'h20, 8'h20, 1'b1, 1'b0);
      chk("R9 set wins", vector, 8'h18);

      // R6: enable off
      step(8'h00, 8'h00, 1'b0, 1'b0);
      chk("R6 disabled irq_req", {7'd0, irq_req}, 8'h00);
      chk("R6 vector kept", vector, 8'h18);

      // R7/R8: ignore mode freezes and masks
      snap = vector;
      step(8'h80, 8'h20, 1'b1, 1'b1);
      chk("R7 masked irq_req", {7'd0, irq_req}, 8'h00);
      chk("R8 frozen vector", vector, snap);
      step(8'h01, 8'hFF, 1'b1, 1'b1);
      chk("R8 frozen vector", vector, snap);
      step(8'h00, 8'h00, 1'b1, 1'b0);
      chk("R8 after release", vector, 8'h18);
      chk("R6 request back", {7'd0, irq_req}, 8'h01);

      // random
      for (int k = 0; k < 400; k++) begin
         logic [7:0] s, c;
         s = 8'($urandom & $urandom & $urandom);
         c = 8'($urandom & $urandom);
         step(s, c, 1'($urandom % 4 != 0), 1'($urandom % 5 == 0));
         check_all("R3 random");
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule